// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Index

This block turns the two phase signals of an incremental rotary or linear encoder into a signed position count. It also accepts the encoder's optional once-per-revolution index pulse. Each of the three raw inputs (phase 0, phase 90 and index) passes through its own programmable glitch filter, which runs on the block clock. A change on an input reaches the decoder only after the new level has been sampled on a programmable number of consecutive clock cycles.

The filtered phase pair walks a four-state Gray sequence. A step forward adds one to the position counter and a step backward subtracts one. A jump across two states cannot be decoded, so it is reported as an error and the counter does not move. When index recognition is enabled, an index pulse is accepted only while the filtered phase pair sits in one software-chosen state. An accepted index clears the counter and raises a single-cycle index event.

Software sets the decode enable, the index enable, the index state and the filter length through one 8-bit control register. Single-cycle pulse outputs report steps, errors and index events, and the step direction is held on a level output.

Top module: `quad_index_decoder`

## Requirements
- R1: The control register takes `cfg_wdata` when `cfg_wr` is high and reads back on `cfg_rdata`. The field layout is: bits 6:5 index state select, bit 4 index enable, bit 3 decode enable, bits 2:0 filter length. Bit 7 always reads zero, whatever value was written to it, so writing 0xFF reads back 0x7F.
- R2: With filter length n (0 to 7), an input change is passed on only after the new level has been sampled on n+1 consecutive clocks. A pulse lasting n clocks has no effect, a pulse lasting n+1 clocks gets through, and n = 0 passes a change after a single sample.
- R3: The phase state is {phase0, phase90}. One step in the order 00→01→11→10→00 increments the counter and one step in the reverse order decrements it. The counter wraps modulo 2^CNT_W. Each valid step pulses `step_o` for one clock.
- R4: `dir_o` is 1 after the most recent valid step was an increment and 0 after a decrement. It keeps its value while there are no steps.
- R5: A change of both phase bits at once leaves the counter unchanged and pulses `err_o` for one clock.
- R6: While the decode enable bit is 0, the counter holds, no step, error or index event is produced, and an index is not accepted. Phase changes made while disabled cause no count when decoding is enabled again.
- R7: An index is accepted only when the index enable bit is 1 and the filtered phase state equals the index state select, where select value 2'b01 means phase0 = 0 and phase90 = 1. Otherwise the index input has no effect.
- R8: An accepted index loads zero into the counter and pulses `index_evt_o` for one clock once per acceptance. Zero wins over a count step in the same cycle.
- R9: A synchronous active-high reset clears the counter, direction, pulses, filters and control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the filter sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data, bit 7 always zero |
| ph0_in | input | 1 | Raw phase 0 encoder input |
| ph90_in | input | 1 | Raw phase 90 encoder input |
| index_in | input | 1 | Raw index encoder input |
| count_o | output | CNT_W | Position counter |
| dir_o | output | 1 | Direction of the last valid step (1 = up) |
| step_o | output | 1 | One-clock pulse per valid step |
| err_o | output | 1 | One-clock pulse per double-bit phase change |
| index_evt_o | output | 1 | One-clock pulse per accepted index |

## Verification
The assertions assume the three encoder inputs already belong to the block clock domain, so the filter sees clean samples with no metastability. The bench therefore changes every input only at the falling edge. The counter checks also assume the control register stays the same while a step is in flight. The bench writes the control register only after all filtered inputs have settled, and every glitch it injects is one that the filter either rejects entirely or passes entirely.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

   localparam int FLT_LEN_W = 3;

   typedef struct packed {
      logic [1:0]           idx_sel;
      logic                 idx_en;
      logic                 dec_en;
      logic [FLT_LEN_W-1:0] filt_len;
   } qdec_cfg_t;

   typedef enum logic [1:0] {
      STEP_NONE = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2,
      STEP_BAD  = 2'd3
   } step_t;

   // Gray state {ph0,ph90} -> position 0..3 along the up sequence
   function automatic logic [1:0] gray_to_pos(input logic [1:0] g);
      return {g[1], g[1] ^ g[0]};
   endfunction

endpackage

// File: rtl/qdec_ctrl_reg.sv
module qdec_ctrl_reg
   import qdec_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       wr,
   input  logic [7:0] wdata,
   output qdec_cfg_t  cfg,
   output logic [7:0] rdata
);

   localparam int CFG_W = $bits(qdec_cfg_t);

   if (CFG_W != 7) begin : g_bad_cfg
      $error("control fields must fill exactly seven bits");
   end

   qdec_cfg_t cfg_q;
   logic      unused_rsvd;

   assign unused_rsvd = wdata[7];

   always_ff @(posedge clk) begin
      if (rst)     cfg_q <= '0;
      else if (wr) cfg_q <= qdec_cfg_t'(wdata[CFG_W-1:0]);
   end

   assign cfg   = cfg_q;
   assign rdata = {1'b0, cfg_q};

   // R1
   wr_readback_chk: assert property (@(posedge clk) disable iff (rst)
      wr |=> rdata[6:0] == $past(wdata[6:0]));

endmodule

// File: rtl/qdec_glitch_filter.sv
module qdec_glitch_filter #(
   parameter int LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LEN_W-1:0] len,
   input  logic             din,
   output logic             dout
);

   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("filter length width out of range");
   end

   logic [LEN_W-1:0] run_q;
   logic             out_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_q <= 1'b0;
         run_q <= '0;
      end else if (din == out_q) begin
         run_q <= '0;
      end else if (run_q == len) begin
         out_q <= din;
         run_q <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign dout = out_q;

   // R2
   flt_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (dout != $past(dout)) |-> ($past(din) == dout));

endmodule

// File: rtl/qdec_step_decoder.sv
module qdec_step_decoder
   import qdec_pkg::*;
(
   input  logic [1:0] prev_ph,
   input  logic [1:0] cur_ph,
   output step_t      step
);

   logic [1:0] delta;

   assign delta = gray_to_pos(cur_ph) - gray_to_pos(prev_ph);

   always_comb begin
      unique case (delta)
         2'd0:    step = STEP_NONE;
         2'd1:    step = STEP_UP;
         2'd3:    step = STEP_DOWN;
         default: step = STEP_BAD;
      endcase
   end

endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter
   import qdec_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             idx_en,
   input  logic [1:0]       idx_sel,
   input  logic [1:0]       ph,
   input  logic             idx,
   output logic [CNT_W-1:0] count_o,
   output logic             dir_o,
   output logic             step_o,
   output logic             err_o,
   output logic             idx_evt_o
);

   logic [1:0] prev_q;
   logic       acc_q;
   logic       accept;
   logic       idx_hit;
   step_t      step;

   qdec_step_decoder u_step (
      .prev_ph (prev_q),
      .cur_ph  (ph),
      .step    (step)
   );

   assign accept  = en & idx_en & idx & (ph == idx_sel);
   assign idx_hit = accept & ~acc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q    <= 2'b00;
         acc_q     <= 1'b0;
         count_o   <= '0;
         dir_o     <= 1'b0;
         step_o    <= 1'b0;
         err_o     <= 1'b0;
         idx_evt_o <= 1'b0;
      end else begin
         prev_q    <= ph;
         acc_q     <= accept;
         step_o    <= en & ((step == STEP_UP) | (step == STEP_DOWN));
         err_o     <= en & (step == STEP_BAD);
         idx_evt_o <= idx_hit;
         if (en && step == STEP_UP)   dir_o <= 1'b1;
         if (en && step == STEP_DOWN) dir_o <= 1'b0;
         if (idx_hit)                          count_o <= '0;
         else if (en && step == STEP_UP)       count_o <= count_o + 1'b1;
         else if (en && step == STEP_DOWN)     count_o <= count_o - 1'b1;
      end
   end

   // R6
   hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(count_o) && !step_o && !err_o && !idx_evt_o);

   // R3
   count_up_chk: assert property (@(posedge clk) disable iff (rst)
      (en && step == STEP_UP && !idx_hit) |=>
         (count_o == CNT_W'($past(count_o) + 1'b1)) && dir_o);

   // R3
   count_down_chk: assert property (@(posedge clk) disable iff (rst)
      (en && step == STEP_DOWN && !idx_hit) |=>
         (count_o == CNT_W'($past(count_o) - 1'b1)) && !dir_o);

   // R5
   bad_step_chk: assert property (@(posedge clk) disable iff (rst)
      (en && step == STEP_BAD && !idx_hit) |=> $stable(count_o) && err_o);

   // R8
   index_zero_chk: assert property (@(posedge clk) disable iff (rst)
      idx_hit |=> (count_o == '0) && idx_evt_o);

   // R8
   index_single_chk: assert property (@(posedge clk) disable iff (rst)
      idx_evt_o |=> !idx_evt_o);

   // R5
   pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({step_o, err_o}));

endmodule

// File: rtl/quad_index_decoder.sv
module quad_index_decoder
   import qdec_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_wr,
   input  logic [7:0]       cfg_wdata,
   output logic [7:0]       cfg_rdata,
   input  logic             ph0_in,
   input  logic             ph90_in,
   input  logic             index_in,
   output logic [CNT_W-1:0] count_o,
   output logic             dir_o,
   output logic             step_o,
   output logic             err_o,
   output logic             index_evt_o
);

   localparam int N_IN = 3;

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
      $error("counter width must lie between 2 and 64");
   end

   qdec_cfg_t       cfg;
   logic [N_IN-1:0] raw;
   logic [N_IN-1:0] filt;

   assign raw = {index_in, ph0_in, ph90_in};

   qdec_ctrl_reg u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .cfg   (cfg),
      .rdata (cfg_rdata)
   );

   for (genvar i = 0; i < N_IN; i++) begin : g_flt
      qdec_glitch_filter #(.LEN_W(FLT_LEN_W)) u_flt (
         .clk  (clk),
         .rst  (rst),
         .len  (cfg.filt_len),
         .din  (raw[i]),
         .dout (filt[i])
      );
   end

   qdec_pos_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .en        (cfg.dec_en),
      .idx_en    (cfg.idx_en),
      .idx_sel   (cfg.idx_sel),
      .ph        (filt[1:0]),
      .idx       (filt[2]),
      .count_o   (count_o),
      .dir_o     (dir_o),
      .step_o    (step_o),
      .err_o     (err_o),
      .idx_evt_o (index_evt_o)
   );

endmodule

// File: tb/quad_index_decoder_tb.sv
module quad_index_decoder_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        ph0_in = 1'b0, ph90_in = 1'b0, index_in = 1'b0;
   logic [15:0] count_o;
   logic        dir_o, step_o, err_o, index_evt_o;

   int checks = 0, errors = 0;
   int n_step = 0, n_err = 0, n_idx = 0;
   bit done = 0;

   int         exp_cnt = 0;
   bit         exp_dir = 0;
   logic [1:0] cur = 2'b00;
   bit         m_dec = 0, m_ien = 0;
   logic [1:0] m_sel = 0;
   int         m_filt = 0;

   always #4 clk = ~clk;

   quad_index_decoder #(.CNT_W(16)) u_dut (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .ph0_in(ph0_in), .ph90_in(ph90_in),
      .index_in(index_in), .count_o(count_o), .dir_o(dir_o),
      .step_o(step_o), .err_o(err_o), .index_evt_o(index_evt_o)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (step_o)      n_step++;
         if (err_o)       n_err++;
         if (index_evt_o) n_idx++;
      end
   end

   function automatic int pos_of(input logic [1:0] s);
      case (s)
         2'b00: return 0;
         2'b01: return 1;
         2'b11: return 2;
         default: return 3;
      endcase
   endfunction

   function automatic logic [1:0] state_of(input int p);
      case (p & 3)
         0: return 2'b00;
         1: return 2'b01;
         2: return 2'b11;
         default: return 2'b10;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (m_filt + 4) @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic set_cfg(input bit dec, input bit ien, input logic [1:0] sel, input int filt);
      m_dec = dec; m_ien = ien; m_sel = sel; m_filt = filt;
      wr_cfg({1'b0, sel, ien, dec, 3'(filt)});
      settle();
   endtask

   task automatic drive_state(input logic [1:0] s);
      int d;
      @(negedge clk);
      {ph0_in, ph90_in} = s;
      settle();
      if (m_dec) begin
         d = (pos_of(s) - pos_of(cur)) & 3;
         if (d == 1)      begin exp_cnt = (exp_cnt + 1) & 16'hFFFF; exp_dir = 1; end
         else if (d == 3) begin exp_cnt = (exp_cnt - 1) & 16'hFFFF; exp_dir = 0; end
      end
      cur = s;
   endtask

   task automatic walk_to(input logic [1:0] s);
      while (cur != s) drive_state(state_of(pos_of(cur) + 1));
   endtask

   task automatic glitch(input logic [1:0] s, input int width);
      @(negedge clk);
      {ph0_in, ph90_in} = s;
      repeat (width) @(negedge clk);
      {ph0_in, ph90_in} = cur;
      settle();
   endtask

   task automatic pulse_idx();
      @(negedge clk);
      index_in = 1'b1;
      repeat (m_filt + 4) @(negedge clk);
      index_in = 1'b0;
      settle();
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int s0, e0, i0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9 reset state
      chk("R9 count", count_o, 0);
      chk("R9 dir", dir_o, 0);
      chk("R9 rdata", cfg_rdata, 0);
      chk("R9 pulses", {step_o, err_o, index_evt_o}, 0);

      // R1 readback, reserved bit 7 reads zero
      wr_cfg(8'hFF);  @(negedge clk); chk("R1 ff", cfg_rdata, 8'h7F);
      wr_cfg(8'h80);  @(negedge clk); chk("R1 80", cfg_rdata, 8'h00);
      wr_cfg(8'hDD);  @(negedge clk); chk("R1 dd", cfg_rdata, 8'h5D);

      // R3 / R4 counting both ways with wrap
      set_cfg(1, 0, 2'b00, 0);
      s0 = n_step;
      for (int k = 0; k < 8; k++) drive_state(state_of(pos_of(cur) + 1));
      chk("R3 up count", count_o, exp_cnt);
      chk("R3 up value", count_o, 8);
      chk("R4 up dir", dir_o, 1);
      chk("R3 step pulses", n_step - s0, 8);
      for (int k = 0; k < 11; k++) drive_state(state_of(pos_of(cur) + 3));
      chk("R3 wrap value", count_o, 16'hFFFD);
      chk("R4 down dir", dir_o, 0);

      // R2 filter sweep over every length
      for (int n = 0; n < 8; n++) begin
         set_cfg(1, 0, 2'b00, n);
         if (n > 0) begin
            s0 = n_step;
            glitch(state_of(pos_of(cur) + 1), n);
            chk($sformatf("R2 short pulse n=%0d steps", n), n_step - s0, 0);
            chk($sformatf("R2 short pulse n=%0d count", n), count_o, exp_cnt);
         end
         s0 = n_step;
         glitch(state_of(pos_of(cur) + 1), n + 1);
         chk($sformatf("R2 long pulse n=%0d steps", n), n_step - s0, 2);
         chk($sformatf("R2 long pulse n=%0d count", n), count_o, exp_cnt);
         drive_state(state_of(pos_of(cur) + 1));
         chk($sformatf("R2 held n=%0d count", n), count_o, exp_cnt);
      end

      // R5 double change
      set_cfg(1, 0, 2'b00, 0);
      for (int k = 0; k < 4; k++) begin
         s0 = n_step; e0 = n_err;
         drive_state(cur ^ 2'b11);
         chk("R5 count held", count_o, exp_cnt);
         chk("R5 err pulse", n_err - e0, 1);
         chk("R5 no step", n_step - s0, 0);
      end

      // R6 decode disabled
      set_cfg(0, 1, 2'b00, 0);
      s0 = n_step; i0 = n_idx;
      drive_state(state_of(pos_of(cur) + 1));
      drive_state(state_of(pos_of(cur) + 1));
      walk_to(2'b00);
      pulse_idx();
      chk("R6 count held", count_o, exp_cnt);
      chk("R6 no steps", n_step - s0, 0);
      chk("R6 no index", n_idx - i0, 0);
      set_cfg(1, 0, 2'b00, 0);
      chk("R6 reenable count", count_o, exp_cnt);
      chk("R6 reenable steps", n_step - s0, 0);

      // R7 / R8 index sweep over enable, select and phase state
      for (int ie = 0; ie < 2; ie++) begin
         for (int sel = 0; sel < 4; sel++) begin
            set_cfg(1, ie[0], 2'(sel), 1);
            for (int t = 0; t < 4; t++) begin
               for (int k = 0; k < 4; k++) drive_state(state_of(pos_of(cur) + 1));
               walk_to(2'(t));
               i0 = n_idx;
               pulse_idx();
               if (ie == 1 && t == sel) begin
                  exp_cnt = 0;
                  chk($sformatf("R8 event sel=%0d", sel), n_idx - i0, 1);
               end else begin
                  chk($sformatf("R7 ignored ie=%0d sel=%0d st=%0d", ie, sel, t), n_idx - i0, 0);
               end
               chk($sformatf("R7 count ie=%0d sel=%0d st=%0d", ie, sel, t), count_o, exp_cnt);
            end
         end
      end

      // R8 index beats a simultaneous step
      set_cfg(1, 1, 2'b11, 0);
      walk_to(2'b01);
      drive_state(2'b00);
      walk_to(2'b01);
      chk("R8 pre count nonzero", (count_o != 0) ? 1 : 0, 1);
      s0 = n_step; i0 = n_idx;
      @(negedge clk);
      {ph0_in, ph90_in} = 2'b11;
      index_in = 1'b1;
      settle();
      cur = 2'b11; exp_cnt = 0; exp_dir = 1;
      chk("R8 priority count", count_o, 0);
      chk("R8 priority event", n_idx - i0, 1);
      chk("R8 priority step", n_step - s0, 1);
      index_in = 1'b0;
      settle();
      drive_state(state_of(pos_of(cur) + 1));
      chk("R8 count after zero", count_o, 1);
      chk("R4 dir after index", dir_o, 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule